// File: doc/BRIEF.md
# Particle Binning and Refinement Classifier

This block takes one particle per cycle, given as X/Y coordinates in unsigned Q16.16 fixed point together with the origin of the current mesh level, the block edge length as a power-of-two shift amount, and a mass. It works out which block of a 16 x 16 grid the particle falls in and where inside that block it sits. The two block coordinates are bit-interleaved into an 8-bit Z-order key. That key selects a section base address and a running occupancy count from two on-chip tables. The particle leaves with a write address (base plus count) and a payload of its in-block offset and mass. Particles are therefore scattered into sections laid out in spatial order.

The same occupancy counters drive the mesh decisions. On command the block walks every key in ascending order, one per cycle. For each block it emits a two-bit verdict: refine when the block is crowded, coarsen when its four edge neighbours are nearly empty, and keep otherwise. Section bases are written through a simple load port while the pipeline is empty, and a clear pin zeroes all counters at the start of a time step.

Both particle streams use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output beat holds every field unchanged. Back-pressure reaches `in_ready` once both internal stages are full. `in_ready` is also low while a scan runs and in any cycle where `cls_start` is high.

Top module: `zb_sorter`

## Requirements
- R1: The block coordinate on each axis is the low 4 bits of floor((c - origin) / 2^in_shift), where c - origin wraps modulo 2^32. The offset on each axis (`out_dx`, `out_dy`) is the fractional part of that quotient, given in unsigned Q0.16.
- R2: The key `out_key` interleaves the block coordinates. Key bit 2i is bit i of the X coordinate and key bit 2i+1 is bit i of the Y coordinate.
- R3: `out_addr` equals the section base of the key plus that key's count of particles accepted before this one (modulo 2^16), and the count then rises by one. Back-to-back particles in the same block therefore get consecutive addresses.
- R4: `out_mass` carries the particle's mass unchanged, and particles leave in the order they arrived.
- R5: While `out_valid` is high and `out_ready` is low, every output field holds. With both stages full and the output stalled, `in_ready` is low. No particle is lost or duplicated.
- R6: A `clr` pulse sets every count to zero. `ld_en` writes `ld_base` as the section base of `ld_key`, and later particles use that base.
- R7: A scan started by `cls_start` raises `busy` and `dec_valid` for exactly 256 cycles. `dec_key` runs 0, 1, ... 255, one per cycle, and `in_ready` stays low throughout the scan.
- R8: A block whose count is strictly greater than `thr_refine` gets decision code 01 (refine).
- R9: Any block not refined gets code 10 (coarsen) when the summed count of its in-grid left, right, lower and upper neighbours is strictly less than `thr_coarsen`. Otherwise it gets code 00 (keep). Code 11 never appears.
- R10: After reset `out_valid`, `busy` and `dec_valid` are low, `in_ready` is high, and all counts are zero.
- R11: `cls_start` is ignored when a particle is still inside the pipeline or a scan is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input particle valid |
| in_ready | output | 1 | Input particle accepted when high |
| in_x | input | 32 | X coordinate, Q16.16 |
| in_y | input | 32 | Y coordinate, Q16.16 |
| in_org_x | input | 32 | Level origin X, Q16.16 |
| in_org_y | input | 32 | Level origin Y, Q16.16 |
| in_shift | input | 5 | log2 of block edge length in raw Q16.16 units (16 means 1.0) |
| in_mass | input | 16 | Particle mass |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_addr | output | 16 | Destination write address |
| out_key | output | 8 | Z-order block key |
| out_dx | output | 16 | X offset in block, Q0.16 |
| out_dy | output | 16 | Y offset in block, Q0.16 |
| out_mass | output | 16 | Particle mass |
| ld_en | input | 1 | Write section base |
| ld_key | input | 8 | Key whose base is written |
| ld_base | input | 16 | Base value written |
| clr | input | 1 | Zero all counts |
| cls_start | input | 1 | Start a classification scan |
| thr_refine | input | 16 | Refine when count exceeds this |
| thr_coarsen | input | 16 | Coarsen when neighbour sum is below this |
| busy | output | 1 | Scan in progress |
| dec_valid | output | 1 | Decision valid this cycle |
| dec_key | output | 8 | Key of the current decision |
| dec_code | output | 2 | 00 keep, 01 refine, 10 coarsen |

## Verification
The bound checker watches on every cycle that a stalled output beat holds its fields and that a scan blocks the input. It also checks that scan keys step by exactly one, that code 11 never appears, that a start pulse cannot open a scan while a particle waits at the output, and that two consecutive beats of the same block differ by one in address. Only the directed scenarios can show the arithmetic itself. That covers floor and fraction results for several block lengths and origins, wrapping of out-of-range block coordinates, and base-plus-count addressing across a clear and a base reload. It also covers the full set of 256 decisions against counts the bench built up, including blocks sitting exactly on either threshold.

// File: rtl/zb_pkg.sv
package zb_pkg;
  typedef enum logic [1:0] {
    DEC_KEEP    = 2'b00,
    DEC_REFINE  = 2'b01,
    DEC_COARSEN = 2'b10
  } dec_e;
endpackage

// File: rtl/zb_axis.sv
// One axis of the locate step: subtract the origin, divide by the
// power-of-two block length, split into block index and Q0.F fraction.
module zb_axis #(
  parameter int COORD_W = 32,
  parameter int FRAC_W  = 16,
  parameter int AXIS_W  = 4,
  parameter int SHIFT_W = 5
) (
  input  logic [COORD_W-1:0] coord,
  input  logic [COORD_W-1:0] org,
  input  logic [SHIFT_W-1:0] shift,
  output logic [AXIS_W-1:0]  blk,
  output logic [FRAC_W-1:0]  frac
);
  localparam int WIDE_W = COORD_W + FRAC_W;

  logic [COORD_W-1:0] rel;
  logic [WIDE_W-1:0]  scaled;

  // Appending FRAC_W zero bits keeps the bits shifted out below the
  // binary point, so one shifter yields both quotient and fraction.
  assign rel    = coord - org;
  assign scaled = {rel, {FRAC_W{1'b0}}} >> shift;
  assign frac   = FRAC_W'(scaled);
  assign blk    = AXIS_W'(scaled >> FRAC_W);
endmodule

// File: rtl/zb_zorder.sv
// Bit interleave of two block coordinates into a Z-order key.
module zb_zorder #(
  parameter int AXIS_W = 4,
  localparam int KEY_W = 2 * AXIS_W
) (
  input  logic [AXIS_W-1:0] bx,
  input  logic [AXIS_W-1:0] by,
  output logic [KEY_W-1:0]  key
);
  for (genvar i = 0; i < AXIS_W; i++) begin : g_bit
    assign key[2*i]   = bx[i];
    assign key[2*i+1] = by[i];
  end
endmodule

// File: rtl/zb_tables.sv
// Section base table and per-block occupancy counters.
// One lookup port with commit forwarding, one commit port, NRD scan ports.
module zb_tables #(
  parameter int KEY_W  = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int NRD    = 5,
  localparam int NBLK  = 1 << KEY_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic [KEY_W-1:0]       ld_key,
  input  logic [ADDR_W-1:0]      ld_base,
  input  logic                   clr,
  input  logic [KEY_W-1:0]       lk_key,
  output logic [ADDR_W-1:0]      lk_base,
  output logic [CNT_W-1:0]       lk_cnt,
  input  logic                   cm_en,
  input  logic [KEY_W-1:0]       cm_key,
  input  logic [CNT_W-1:0]       cm_cnt,
  input  logic [NRD*KEY_W-1:0]   rd_keys,
  output logic [NRD*CNT_W-1:0]   rd_cnts
);
  logic [ADDR_W-1:0] base_q [NBLK];
  logic [CNT_W-1:0]  cnt_q  [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        base_q[b] <= '0;
      end
    end else if (ld_en) begin
      base_q[ld_key] <= ld_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int b = 0; b < NBLK; b++) begin
        cnt_q[b] <= '0;
      end
    end else if (cm_en) begin
      cnt_q[cm_key] <= cm_cnt;
    end
  end

  // A count being written back this cycle for the same key wins over the
  // stored copy; a clear in the same cycle wins over both.
  always_comb begin
    lk_base = base_q[lk_key];
    if (clr) begin
      lk_cnt = '0;
    end else if (cm_en && (cm_key == lk_key)) begin
      lk_cnt = cm_cnt;
    end else begin
      lk_cnt = cnt_q[lk_key];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_cnts[r*CNT_W +: CNT_W] = cnt_q[rd_keys[r*KEY_W +: KEY_W]];
  end
endmodule

// File: rtl/zb_classify.sv
// Sequential scan over all keys; one refine/coarsen/keep verdict per cycle.
module zb_classify
  import zb_pkg::*;
#(
  parameter int AXIS_W = 4,
  parameter int CNT_W  = 16,
  localparam int KEY_W = 2 * AXIS_W,
  localparam int NNB   = 4,
  localparam int NRD   = NNB + 1,
  localparam int SUM_W = CNT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     thr_refine,
  input  logic [CNT_W-1:0]     thr_coarsen,
  output logic [NRD*KEY_W-1:0] rd_keys,
  input  logic [NRD*CNT_W-1:0] rd_cnts,
  output logic                 busy,
  output logic                 dec_valid,
  output logic [KEY_W-1:0]     dec_key,
  output logic [1:0]           dec_code
);
  logic              busy_q;
  logic [KEY_W-1:0]  idx_q;
  logic [AXIS_W-1:0] cx, cy;
  logic [AXIS_W-1:0] nx [NNB];
  logic [AXIS_W-1:0] ny [NNB];
  logic [NNB-1:0]    nv;
  logic [SUM_W-1:0]  nsum;
  logic [CNT_W-1:0]  own;
  dec_e              verdict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      idx_q <= idx_q + KEY_W'(1);
      if (idx_q == '1) begin
        busy_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < AXIS_W; i++) begin : g_split
    assign cx[i] = idx_q[2*i];
    assign cy[i] = idx_q[2*i+1];
  end

  // Neighbours: 0 left, 1 right, 2 lower, 3 upper; off-grid ones drop out.
  always_comb begin
    nx[0] = cx - AXIS_W'(1); ny[0] = cy;                nv[0] = (cx != '0);
    nx[1] = cx + AXIS_W'(1); ny[1] = cy;                nv[1] = (cx != '1);
    nx[2] = cx;              ny[2] = cy - AXIS_W'(1);   nv[2] = (cy != '0);
    nx[3] = cx;              ny[3] = cy + AXIS_W'(1);   nv[3] = (cy != '1);
  end

  assign rd_keys[0 +: KEY_W] = idx_q;
  for (genvar n = 0; n < NNB; n++) begin : g_nb
    zb_zorder #(.AXIS_W(AXIS_W)) u_nkey (
      .bx  (nx[n]),
      .by  (ny[n]),
      .key (rd_keys[(n+1)*KEY_W +: KEY_W])
    );
  end

  always_comb begin
    nsum = '0;
    for (int n = 0; n < NNB; n++) begin
      if (nv[n]) begin
        nsum = nsum + SUM_W'(rd_cnts[(n+1)*CNT_W +: CNT_W]);
      end
    end
  end

  assign own = rd_cnts[0 +: CNT_W];

  always_comb begin
    if (own > thr_refine) begin
      verdict = DEC_REFINE;
    end else if (nsum < SUM_W'(thr_coarsen)) begin
      verdict = DEC_COARSEN;
    end else begin
      verdict = DEC_KEEP;
    end
  end

  assign busy      = busy_q;
  assign dec_valid = busy_q;
  assign dec_key   = idx_q;
  assign dec_code  = verdict;
endmodule

// File: rtl/zb_sorter.sv
// Top: locate -> key -> base+count address, two-stage valid/ready pipe,
// plus the classification scan sharing the counter table.
module zb_sorter #(
  parameter int COORD_W = 32,
  parameter int FRAC_W  = 16,
  parameter int AXIS_W  = 4,
  parameter int SHIFT_W = 5,
  parameter int MASS_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  localparam int KEY_W  = 2 * AXIS_W,
  localparam int NRD    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [COORD_W-1:0] in_org_x,
  input  logic [COORD_W-1:0] in_org_y,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [MASS_W-1:0]  in_mass,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [KEY_W-1:0]   out_key,
  output logic [FRAC_W-1:0]  out_dx,
  output logic [FRAC_W-1:0]  out_dy,
  output logic [MASS_W-1:0]  out_mass,
  input  logic               ld_en,
  input  logic [KEY_W-1:0]   ld_key,
  input  logic [ADDR_W-1:0]  ld_base,
  input  logic               clr,
  input  logic               cls_start,
  input  logic [CNT_W-1:0]   thr_refine,
  input  logic [CNT_W-1:0]   thr_coarsen,
  output logic               busy,
  output logic               dec_valid,
  output logic [KEY_W-1:0]   dec_key,
  output logic [1:0]         dec_code
);
  // Locate stage (combinational on the input beat)
  logic [AXIS_W-1:0] bx, by;
  logic [FRAC_W-1:0] fx, fy;
  logic [KEY_W-1:0]  key_in;

  zb_axis #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .AXIS_W(AXIS_W), .SHIFT_W(SHIFT_W))
    u_ax_x (.coord(in_x), .org(in_org_x), .shift(in_shift), .blk(bx), .frac(fx));
  zb_axis #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .AXIS_W(AXIS_W), .SHIFT_W(SHIFT_W))
    u_ax_y (.coord(in_y), .org(in_org_y), .shift(in_shift), .blk(by), .frac(fy));
  zb_zorder #(.AXIS_W(AXIS_W)) u_key (.bx(bx), .by(by), .key(key_in));

  // Stage 1: keyed particle
  logic              s1_v;
  logic [KEY_W-1:0]  s1_key;
  logic [FRAC_W-1:0] s1_dx, s1_dy;
  logic [MASS_W-1:0] s1_mass;
  // Stage 2: addressed particle (drives the output)
  logic              s2_v;
  logic [KEY_W-1:0]  s2_key;
  logic [CNT_W-1:0]  s2_cnt;
  logic [ADDR_W-1:0] s2_addr;
  logic [FRAC_W-1:0] s2_dx, s2_dy;
  logic [MASS_W-1:0] s2_mass;

  logic s2_free, s1_free, in_fire, adv12, commit, scan_go, scan_busy;
  logic [ADDR_W-1:0] lk_base;
  logic [CNT_W-1:0]  lk_cnt;
  logic [NRD*KEY_W-1:0] rd_keys;
  logic [NRD*CNT_W-1:0] rd_cnts;

  assign s2_free  = !s2_v || out_ready;
  assign s1_free  = !s1_v || s2_free;
  assign in_ready = s1_free && !scan_busy && !cls_start;
  assign in_fire  = in_valid && in_ready;
  assign adv12    = s1_v && s2_free;
  assign commit   = s2_v && out_ready;
  assign scan_go  = cls_start && !scan_busy && !s1_v && !s2_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else if (in_fire) begin
      s1_v <= 1'b1;
    end else if (adv12) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_key  <= key_in;
      s1_dx   <= fx;
      s1_dy   <= fy;
      s1_mass <= in_mass;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
    end else if (adv12) begin
      s2_v <= 1'b1;
    end else if (commit) begin
      s2_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (adv12) begin
      s2_key  <= s1_key;
      s2_cnt  <= lk_cnt;
      s2_addr <= lk_base + ADDR_W'(lk_cnt);
      s2_dx   <= s1_dx;
      s2_dy   <= s1_dy;
      s2_mass <= s1_mass;
    end
  end

  zb_tables #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NRD(NRD)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_key  (ld_key),
    .ld_base (ld_base),
    .clr     (clr),
    .lk_key  (s1_key),
    .lk_base (lk_base),
    .lk_cnt  (lk_cnt),
    .cm_en   (commit),
    .cm_key  (s2_key),
    .cm_cnt  (s2_cnt + CNT_W'(1)),
    .rd_keys (rd_keys),
    .rd_cnts (rd_cnts)
  );

  zb_classify #(.AXIS_W(AXIS_W), .CNT_W(CNT_W)) u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (scan_go),
    .thr_refine  (thr_refine),
    .thr_coarsen (thr_coarsen),
    .rd_keys     (rd_keys),
    .rd_cnts     (rd_cnts),
    .busy        (scan_busy),
    .dec_valid   (dec_valid),
    .dec_key     (dec_key),
    .dec_code    (dec_code)
  );

  assign busy      = scan_busy;
  assign out_valid = s2_v;
  assign out_addr  = s2_addr;
  assign out_key   = s2_key;
  assign out_dx    = s2_dx;
  assign out_dy    = s2_dy;
  assign out_mass  = s2_mass;
endmodule

// File: rtl/zb_sorter_chk.sv
module zb_sorter_chk #(
  parameter int KEY_W  = 8,
  parameter int ADDR_W = 16,
  parameter int MASS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [KEY_W-1:0]  out_key,
  input logic [MASS_W-1:0] out_mass,
  input logic              ld_en,
  input logic              clr,
  input logic              busy,
  input logic              dec_valid,
  input logic [KEY_W-1:0]  dec_key,
  input logic [1:0]        dec_code
);
  logic              fire;
  logic              last_v;
  logic [KEY_W-1:0]  last_key;
  logic [ADDR_W-1:0] last_addr;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || ld_en) begin
      last_v <= 1'b0;
    end else if (fire) begin
      last_v    <= 1'b1;
      last_key  <= out_key;
      last_addr <= out_addr;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_key) && $stable(out_mass)) // R5
    else $error("stalled output beat changed");

  AST_SCAN_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready) // R7
    else $error("input accepted during scan");

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(dec_valid) |-> (dec_key - $past(dec_key)) == KEY_W'(1)) // R7
    else $error("scan key did not step by one");

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_code != 2'b11) // R9
    else $error("illegal decision code");

  AST_SAME_BLOCK_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_v && (out_key == last_key) |-> out_addr == last_addr + ADDR_W'(1)) // R3
    else $error("same-block addresses not consecutive");

  AST_START_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && out_valid |=> !busy) // R11
    else $error("scan opened with a particle in flight");
endmodule

bind zb_sorter zb_sorter_chk #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .MASS_W(MASS_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_key   (out_key),
  .out_mass  (out_mass),
  .ld_en     (ld_en),
  .clr       (clr),
  .busy      (busy),
  .dec_valid (dec_valid),
  .dec_key   (dec_key),
  .dec_code  (dec_code)
);

// File: tb/zb_sorter_tb_top.sv
module zb_sorter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int QMAX       = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_x, in_y, in_org_x, in_org_y;
  logic [4:0]  in_shift;
  logic [15:0] in_mass;
  logic        out_valid, out_ready;
  logic [15:0] out_addr, out_dx, out_dy, out_mass;
  logic [7:0]  out_key;
  logic        ld_en;
  logic [7:0]  ld_key;
  logic [15:0] ld_base;
  logic        clr, cls_start;
  logic [15:0] thr_refine, thr_coarsen;
  logic        busy, dec_valid;
  logic [7:0]  dec_key;
  logic [1:0]  dec_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  zb_sorter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_org_x(in_org_x), .in_org_y(in_org_y),
    .in_shift(in_shift), .in_mass(in_mass), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_key(out_key),
    .out_dx(out_dx), .out_dy(out_dy), .out_mass(out_mass), .ld_en(ld_en),
    .ld_key(ld_key), .ld_base(ld_base), .clr(clr), .cls_start(cls_start),
    .thr_refine(thr_refine), .thr_coarsen(thr_coarsen), .busy(busy),
    .dec_valid(dec_valid), .dec_key(dec_key), .dec_code(dec_code)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench-side model state
  logic [15:0] base_m [256];
  logic [15:0] cnt_m  [256];
  logic [15:0] e_addr [QMAX], e_dx [QMAX], e_dy [QMAX], e_mass [QMAX];
  logic [7:0]  e_key  [QMAX];
  logic [15:0] r_addr [QMAX], r_dx [QMAX], r_dy [QMAX], r_mass [QMAX];
  logic [7:0]  r_key  [QMAX];
  int n_exp = 0;
  int n_rec = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mix(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] k;
    for (int i = 0; i < 4; i++) begin
      k[2*i]   = x[i];
      k[2*i+1] = y[i];
    end
    return k;
  endfunction

  // Block index and Q0.16 offset from the requirement: remainder * 2^16 / 2^sh
  function automatic void place(input logic [31:0] c, input logic [31:0] o, input int sh,
                                output logic [3:0] b, output logic [15:0] f);
    logic [31:0] d;
    logic [63:0] rem;
    d   = c - o;
    b   = 4'(d / (64'd1 << sh));
    rem = 64'(d) % (64'd1 << sh);
    f   = 16'((rem * 64'd65536) / (64'd1 << sh));
  endfunction

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    if (out_valid && out_ready && n_rec < QMAX) begin
      r_addr[n_rec] = out_addr; r_key[n_rec] = out_key;
      r_dx[n_rec]   = out_dx;   r_dy[n_rec]  = out_dy;
      r_mass[n_rec] = out_mass;
      n_rec++;
    end
  end

  task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [31:0] ox,
                      input logic [31:0] oy, input int sh, input logic [15:0] m);
    logic [3:0] bx, by;
    logic [15:0] fx, fy;
    logic [7:0] k;
    place(x, ox, sh, bx, fx);
    place(y, oy, sh, by, fy);
    k = mix(bx, by);
    e_key[n_exp] = k; e_dx[n_exp] = fx; e_dy[n_exp] = fy; e_mass[n_exp] = m;
    e_addr[n_exp] = base_m[k] + cnt_m[k];
    cnt_m[k] = cnt_m[k] + 16'd1;
    n_exp++;
    in_x = x; in_y = y; in_org_x = ox; in_org_y = oy; in_shift = 5'(sh); in_mass = m;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain_and_compare(input string tag);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int c = 0; c < 40 && n_rec < n_exp; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(n_rec == n_exp, "R5", {tag, " beat count"}, 64'(n_rec), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      check(r_key[i] == e_key[i], "R2", {tag, " key"}, 64'(r_key[i]), 64'(e_key[i]));
      check(r_dx[i] == e_dx[i] && r_dy[i] == e_dy[i], "R1", {tag, " offset"},
            {r_dx[i], r_dy[i]}, {e_dx[i], e_dy[i]});
      check(r_mass[i] == e_mass[i], "R4", {tag, " mass"}, 64'(r_mass[i]), 64'(e_mass[i]));
      check(r_addr[i] == e_addr[i], "R3", {tag, " address"}, 64'(r_addr[i]), 64'(e_addr[i]));
    end
    n_exp = 0;
    n_rec = 0;
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int k = 0; k < 256; k++) cnt_m[k] = 16'd0;
  endtask

  task automatic load_base(input logic [7:0] k, input logic [15:0] b);
    ld_en = 1'b1; ld_key = k; ld_base = b;
    @(negedge clk);
    ld_en = 1'b0;
    base_m[k] = b;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    #2;
    check(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 0);
    check(busy == 1'b0 && dec_valid == 1'b0, "R10", "scan idle after reset",
          64'({busy, dec_valid}), 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 1);
  endtask

  task automatic t_load_all();
    for (int k = 0; k < 256; k++) load_base(8'(k), 16'(100 + k * 24));
    pulse_clear();
  endtask

  task automatic t_locate();
    out_ready = 1'b1;
    send(32'h0003_4000, 32'h0005_8000, 32'h0, 32'h0, 16, 16'h1111);      // len 1.0
    send(32'h000A_C000, 32'h0002_0000, 32'h0001_0000, 32'h0, 17, 16'h2222); // len 2.0
    send(32'h0000_C000, 32'h0001_2000, 32'h0, 32'h0, 14, 16'h3333);      // len 0.25
    send(32'h0014_8000, 32'h0000_0000, 32'h0, 32'h0, 16, 16'h4444);      // X wraps to 4
    send(32'h0003_0001, 32'h000F_FFFF, 32'h0002_0000, 32'h0, 16, 16'h5555); // fine fraction
    drain_and_compare("locate");
  endtask

  task automatic t_same_block();
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++)
      send(32'h0007_1000 + 32'(i * 'h100), 32'h0009_2000, 32'h0, 32'h0, 16, 16'(i + 1));
    drain_and_compare("R3 back-to-back");
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    out_ready = 1'b0;
    send(32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 16, 16'hAAAA);
    send(32'h0001_8000, 32'h0001_8000, 32'h0, 32'h0, 16, 16'hBBBB);
    in_valid = 1'b0;
    #2;
    check(in_ready == 1'b0, "R5", "in_ready with full stalled pipe", 64'(in_ready), 0);
    held = out_addr;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b1 && out_addr == held, "R5", "stalled beat held",
          64'(out_addr), 64'(held));
    drain_and_compare("R5 stall");
  endtask

  task automatic t_clear_load();
    pulse_clear();
    out_ready = 1'b1;
    send(32'h0003_4000, 32'h0005_8000, 32'h0, 32'h0, 16, 16'h0101);  // count restarts, R6
    drain_and_compare("R6 clear");
    load_base(mix(4'd3, 4'd5), 16'h4000);
    send(32'h0003_2000, 32'h0005_1000, 32'h0, 32'h0, 16, 16'h0202);  // new base + 1, R6
    drain_and_compare("R6 load");
  endtask

  task automatic t_start_ignored();
    out_ready = 1'b0;
    send(32'h0002_0000, 32'h0002_0000, 32'h0, 32'h0, 16, 16'h0C0C);
    in_valid  = 1'b0;
    cls_start = 1'b1;
    @(negedge clk);
    cls_start = 1'b0;
    #2;
    check(busy == 1'b0 && dec_valid == 1'b0, "R11", "start ignored while in flight",
          64'({busy, dec_valid}), 0);
    drain_and_compare("R11 flight");
  endtask

  task automatic t_classify();
    logic [1:0] got [256];
    int seen;
    bit order_ok, leak;
    pulse_clear();
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) send(32'h0002_1000, 32'h0002_1000, 0, 0, 16, 16'd1);
    for (int i = 0; i < 2; i++) send(32'h0003_1000, 32'h0002_1000, 0, 0, 16, 16'd1);
    send(32'h0000_1000, 32'h0000_1000, 0, 0, 16, 16'd1);
    for (int i = 0; i < 3; i++) send(32'h0005_1000, 32'h0005_1000, 0, 0, 16, 16'd1);
    drain_and_compare("classify setup");
    thr_refine  = 16'd3;
    thr_coarsen = 16'd2;
    for (int k = 0; k < 256; k++) got[k] = 2'b11;
    cls_start = 1'b1;
    @(negedge clk);
    cls_start = 1'b0;
    seen = 0; order_ok = 1; leak = 0;
    for (int c = 0; c < 300; c++) begin
      #2;
      if (dec_valid) begin
        if (dec_key != 8'(seen)) order_ok = 0;
        if (in_ready || !busy) leak = 1;
        got[dec_key] = dec_code;
        seen++;
      end
      @(negedge clk);
    end
    check(seen == 256, "R7", "decision count", 64'(seen), 256);
    check(order_ok, "R7", "ascending key order", 64'(order_ok), 1);
    check(!leak, "R7", "input blocked and busy during scan", 64'(leak), 0);
    for (int k = 0; k < 256; k++) begin
      logic [3:0] x, y;
      int sum;
      logic [1:0] exp;
      for (int i = 0; i < 4; i++) begin
        x[i] = 1'(k >> (2*i));
        y[i] = 1'(k >> (2*i + 1));
      end
      sum = 0;
      if (x != 4'd0)  sum += int'(cnt_m[mix(x - 4'd1, y)]);
      if (x != 4'd15) sum += int'(cnt_m[mix(x + 4'd1, y)]);
      if (y != 4'd0)  sum += int'(cnt_m[mix(x, y - 4'd1)]);
      if (y != 4'd15) sum += int'(cnt_m[mix(x, y + 4'd1)]);
      if (cnt_m[k] > thr_refine) exp = 2'b01;
      else if (sum < int'(thr_coarsen)) exp = 2'b10;
      else exp = 2'b00;
      check(got[k] == exp, (exp == 2'b01) ? "R8" : "R9", $sformatf("decision key %0d", k),
            64'(got[k]), 64'(exp));
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_x = '0; in_y = '0; in_org_x = '0; in_org_y = '0; in_shift = '0; in_mass = '0;
    ld_en = 1'b0; ld_key = '0; ld_base = '0; clr = 1'b0; cls_start = 1'b0;
    thr_refine = '0; thr_coarsen = '0;
    for (int k = 0; k < 256; k++) begin
      base_m[k] = 16'd0;
      cnt_m[k]  = 16'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_all();
    t_locate();
    t_same_block();
    t_backpressure();
    t_clear_load();
    t_start_ignored();
    t_classify();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule